// File: doc/BRIEF.md
# WFI Sleep and Trap Arbiter

This block decides the fate of a wait-for-interrupt instruction once it reaches the execute stage of a small core that has a machine mode and a user mode. Each cycle the pipeline presents the instruction's address together with the hart's privilege, the timeout-wait and global interrupt-enable bits of the machine status register, the execute-permission verdict of the memory protection unit for that fetch, and the machine interrupt enable and pending vectors. From these the arbiter picks exactly one result. It can take an interrupt, raise an instruction access fault, raise an illegal-instruction exception, retire the instruction and continue, or put the hart to sleep.

Whenever a trap is chosen, the arbiter also supplies the trap cause and the exception return address. For a retirement it supplies the address at which execution continues. While the hart sleeps, the block holds the instruction's address and watches the enabled pending interrupts. When one appears it wakes the hart and either takes the interrupt or lets the hart continue after the instruction. A faulting or trapping instruction never puts the hart to sleep. In user mode an interrupt is taken even when the global machine enable is clear.

Top module: `wfi_arbiter`

## Requirements
- R1: After synchronous reset, `retire_o`, `trap_o`, `sleep_o` and `wake_o` are all low.
- R2: An interrupt is taken when `mie_i & mip_i` is nonzero and the hart is in user mode or `mstatus_mie_i` is 1. This takes priority over every other outcome. The cause has bit XLEN-1 set and the index of the highest-numbered enabled pending line in its low bits. The return address equals the instruction's own address.
- R3: In user mode an interrupt is taken even when `mstatus_mie_i` is 0. When no `mie_i` bit is set, no interrupt is taken.
- R4: When no interrupt is taken and `fetch_x_ok_i` is 0, an instruction access fault is raised with cause 1 and return address equal to the instruction's address. This wins over the illegal-instruction check, and the hart does not sleep.
- R5: In user mode with `mstatus_tw_i` at 1, when no interrupt or fault applies, an illegal-instruction exception is raised with cause 2 and return address equal to the instruction's address. The hart does not sleep, even with no interrupt source enabled.
- R6: In machine mode `mstatus_tw_i` has no effect.
- R7: When no trap applies and `mie_i & mip_i` is nonzero, the instruction retires without sleeping. `target_pc_o` is then the instruction's address plus 4.
- R8: When no trap applies and `mie_i & mip_i` is zero, `sleep_o` rises and neither `retire_o` nor `trap_o` pulses.
- R9: While asleep, the hart stays asleep as long as `mie_i & mip_i` is zero. Lines pending but not enabled do not wake it, and `wfi_valid_i` is ignored.
- R10: On wake, `sleep_o` falls and `wake_o` pulses in the same cycle. If an interrupt is then allowed under R2, `trap_o` pulses with the interrupt cause; otherwise `retire_o` pulses. In both cases `target_pc_o` is the held address plus 4.
- R11: Every result is registered and appears for one cycle, in the cycle after the clock edge that samples the instruction or the wake condition. `retire_o` and `trap_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wfi_valid_i | input | 1 | A wait-for-interrupt instruction is in execute |
| wfi_pc_i | input | XLEN | Address of that instruction |
| priv_user_i | input | 1 | 1 = user mode, 0 = machine mode |
| mstatus_tw_i | input | 1 | Timeout-wait bit (status bit 21) |
| mstatus_mie_i | input | 1 | Global machine interrupt enable |
| fetch_x_ok_i | input | 1 | Execute permission granted for the fetch |
| mie_i | input | NIRQ | Interrupt enable vector |
| mip_i | input | NIRQ | Interrupt pending vector |
| retire_o | output | 1 | Instruction retires, continue at `target_pc_o` |
| trap_o | output | 1 | Trap is taken |
| trap_cause_o | output | XLEN | Trap cause value |
| target_pc_o | output | XLEN | Return address for a trap, next address for a retirement |
| sleep_o | output | 1 | Hart is in the stall state |
| wake_o | output | 1 | One-cycle pulse when the stall ends |

## Verification
Every result appears exactly one clock edge after its cause is sampled: one edge after the instruction is presented, or one edge after an enabled interrupt appears during sleep. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, which is the single cycle in which the one-cycle pulses are high. For the sleep state, the bench holds the inputs for several cycles and checks `sleep_o` in each one. The wake cycle is checked for the falling sleep flag, the wake pulse and the outcome together, and the following cycle is checked for the pulses having cleared.

// File: rtl/wfi_arb_pkg.sv
package wfi_arb_pkg;

    typedef enum logic [1:0] {
        ACT_RETIRE = 2'd0,
        ACT_SLEEP  = 2'd1,
        ACT_TRAP   = 2'd2
    } wfi_act_e;

    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_IRQ     = 2'd1,
        SRC_FETCH   = 2'd2,
        SRC_ILLEGAL = 2'd3
    } trap_src_e;

    typedef struct packed {
        wfi_act_e  act;
        trap_src_e src;
    } wfi_verdict_t;

    localparam int unsigned CAUSE_FETCH_FAULT = 1;
    localparam int unsigned CAUSE_ILLEGAL     = 2;
    localparam int unsigned WFI_BYTES         = 4;

    // Interrupts may be taken in user mode regardless of the global enable.
    function automatic logic irq_allowed(input logic user, input logic glob_en);
        return user | glob_en;
    endfunction

endpackage

// File: rtl/wfi_irq_pick.sv
module wfi_irq_pick #(
    parameter int unsigned NIRQ = 16,
    localparam int unsigned IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic [NIRQ-1:0] en_i,
    input  logic [NIRQ-1:0] pend_i,
    output logic            any_o,
    output logic [IDXW-1:0] idx_o
);
    logic [NIRQ-1:0] live;

    assign live  = en_i & pend_i;
    assign any_o = |live;

    // Highest-numbered live line wins.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < int'(NIRQ); i++) begin
            if (live[i]) idx_o = IDXW'(i);
        end
    end
endmodule

// File: rtl/wfi_verdict.sv
module wfi_verdict
    import wfi_arb_pkg::*;
(
    input  logic         user_i,
    input  logic         tw_i,
    input  logic         glob_en_i,
    input  logic         x_ok_i,
    input  logic         irq_any_i,
    output logic         irq_take_o,
    output wfi_verdict_t verdict_o
);
    assign irq_take_o = irq_any_i & irq_allowed(user_i, glob_en_i);

    always_comb begin
        if (irq_take_o) begin
            verdict_o = '{act: ACT_TRAP, src: SRC_IRQ};
        end else if (!x_ok_i) begin
            verdict_o = '{act: ACT_TRAP, src: SRC_FETCH};
        end else if (user_i && tw_i) begin
            verdict_o = '{act: ACT_TRAP, src: SRC_ILLEGAL};
        end else if (irq_any_i) begin
            verdict_o = '{act: ACT_RETIRE, src: SRC_NONE};
        end else begin
            verdict_o = '{act: ACT_SLEEP, src: SRC_NONE};
        end
    end
endmodule

// File: rtl/wfi_arbiter.sv
module wfi_arbiter
    import wfi_arb_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NIRQ = 16
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            wfi_valid_i,
    input  logic [XLEN-1:0] wfi_pc_i,
    input  logic            priv_user_i,
    input  logic            mstatus_tw_i,
    input  logic            mstatus_mie_i,
    input  logic            fetch_x_ok_i,
    input  logic [NIRQ-1:0] mie_i,
    input  logic [NIRQ-1:0] mip_i,
    output logic            retire_o,
    output logic            trap_o,
    output logic [XLEN-1:0] trap_cause_o,
    output logic [XLEN-1:0] target_pc_o,
    output logic            sleep_o,
    output logic            wake_o
);
    localparam int unsigned IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic            irq_any;
    logic [IDXW-1:0] irq_idx;
    logic            irq_take;
    wfi_verdict_t    verdict;
    logic [XLEN-1:0] held_pc_q;
    logic [XLEN-1:0] irq_cause;

    wfi_irq_pick #(.NIRQ(NIRQ)) u_pick (
        .en_i   (mie_i),
        .pend_i (mip_i),
        .any_o  (irq_any),
        .idx_o  (irq_idx)
    );

    wfi_verdict u_verdict (
        .user_i     (priv_user_i),
        .tw_i       (mstatus_tw_i),
        .glob_en_i  (mstatus_mie_i),
        .x_ok_i     (fetch_x_ok_i),
        .irq_any_i  (irq_any),
        .irq_take_o (irq_take),
        .verdict_o  (verdict)
    );

    always_comb begin
        irq_cause             = '0;
        irq_cause[IDXW-1:0]   = irq_idx;
        irq_cause[XLEN-1]     = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            retire_o     <= 1'b0;
            trap_o       <= 1'b0;
            wake_o       <= 1'b0;
            sleep_o      <= 1'b0;
            trap_cause_o <= '0;
            target_pc_o  <= '0;
            held_pc_q    <= '0;
        end else begin
            retire_o <= 1'b0;
            trap_o   <= 1'b0;
            wake_o   <= 1'b0;
            if (sleep_o) begin
                if (irq_any) begin
                    sleep_o     <= 1'b0;
                    wake_o      <= 1'b1;
                    target_pc_o <= held_pc_q + XLEN'(WFI_BYTES);
                    if (irq_take) begin
                        trap_o       <= 1'b1;
                        trap_cause_o <= irq_cause;
                    end else begin
                        retire_o <= 1'b1;
                    end
                end
            end else if (wfi_valid_i) begin
                unique case (verdict.act)
                    ACT_RETIRE: begin
                        retire_o    <= 1'b1;
                        target_pc_o <= wfi_pc_i + XLEN'(WFI_BYTES);
                    end
                    ACT_SLEEP: begin
                        sleep_o   <= 1'b1;
                        held_pc_q <= wfi_pc_i;
                    end
                    default: begin
                        trap_o      <= 1'b1;
                        target_pc_o <= wfi_pc_i;
                        unique case (verdict.src)
                            SRC_IRQ:   trap_cause_o <= irq_cause;
                            SRC_FETCH: trap_cause_o <= XLEN'(CAUSE_FETCH_FAULT);
                            default:   trap_cause_o <= XLEN'(CAUSE_ILLEGAL);
                        endcase
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/wfi_arbiter_checker.sv
module wfi_arbiter_checker #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NIRQ = 16
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            wfi_valid_i,
    input logic            priv_user_i,
    input logic            mstatus_tw_i,
    input logic            mstatus_mie_i,
    input logic            fetch_x_ok_i,
    input logic [NIRQ-1:0] mie_i,
    input logic [NIRQ-1:0] mip_i,
    input logic            retire_o,
    input logic            trap_o,
    input logic [XLEN-1:0] trap_cause_o,
    input logic            sleep_o,
    input logic            wake_o
);
    logic live_irq;
    logic take_irq;
    assign live_irq = |(mie_i & mip_i);
    assign take_irq = live_irq && (priv_user_i || mstatus_mie_i);

    p_single_result_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({retire_o, trap_o}));

    p_fault_no_sleep_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wfi_valid_i && !sleep_o && !fetch_x_ok_i && !take_irq)
        |=> (trap_o && !sleep_o && trap_cause_o == XLEN'(1)));

    p_tw_no_sleep_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wfi_valid_i && !sleep_o && priv_user_i && mstatus_tw_i)
        |=> (trap_o && !sleep_o));

    p_sleep_holds_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (sleep_o && !live_irq) |=> (sleep_o && !retire_o && !trap_o));

    p_wake_pulse_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (sleep_o && live_irq) |=> (!sleep_o && wake_o && (retire_o || trap_o)));

    p_quiet_entry_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sleep_o) |-> (!retire_o && !trap_o && !wake_o));
endmodule

bind wfi_arbiter wfi_arbiter_checker #(.XLEN(XLEN), .NIRQ(NIRQ)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .wfi_valid_i   (wfi_valid_i),
    .priv_user_i   (priv_user_i),
    .mstatus_tw_i  (mstatus_tw_i),
    .mstatus_mie_i (mstatus_mie_i),
    .fetch_x_ok_i  (fetch_x_ok_i),
    .mie_i         (mie_i),
    .mip_i         (mip_i),
    .retire_o      (retire_o),
    .trap_o        (trap_o),
    .trap_cause_o  (trap_cause_o),
    .sleep_o       (sleep_o),
    .wake_o        (wake_o)
);

// File: tb/wfi_arbiter_test.sv
module wfi_arbiter_test;
    localparam int XLEN = 32;
    localparam int NIRQ = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            valid = 1'b0;
    logic [XLEN-1:0] pc = '0;
    logic            user = 1'b0, tw = 1'b0, gie = 1'b0, xok = 1'b1;
    logic [NIRQ-1:0] en = '0, pend = '0;
    logic            retire, trap, sleep, wake;
    logic [XLEN-1:0] cause, tpc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wfi_arbiter #(.XLEN(XLEN), .NIRQ(NIRQ)) uut (
        .clk_i(clk), .rst_i(rst), .wfi_valid_i(valid), .wfi_pc_i(pc),
        .priv_user_i(user), .mstatus_tw_i(tw), .mstatus_mie_i(gie),
        .fetch_x_ok_i(xok), .mie_i(en), .mip_i(pend),
        .retire_o(retire), .trap_o(trap), .trap_cause_o(cause),
        .target_pc_o(tpc), .sleep_o(sleep), .wake_o(wake)
    );

    typedef struct packed {
        logic        user;
        logic        tw;
        logic        gie;
        logic        xok;
        logic [15:0] en;
        logic [15:0] pend;
        logic        trap;
        logic [31:0] cause;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,16'h0080,16'h0080,1'b1,32'h8000_0007}, // R3 user irq, MIE clear
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,16'h0080,1'b1,32'd2},         // R5 TW, nothing enabled
        '{1'b1,1'b1,1'b0,1'b1,16'h0000,16'h0000,1'b1,32'd2},         // R5 TW, idle
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b1,32'd1},         // R4 fault, none enabled
        '{1'b1,1'b0,1'b0,1'b0,16'hFFFF,16'h0080,1'b1,32'h8000_0007}, // R2 irq beats fault
        '{1'b1,1'b1,1'b0,1'b0,16'h0000,16'h0000,1'b1,32'd1},         // R4 fault beats TW
        '{1'b0,1'b1,1'b0,1'b1,16'h0080,16'h0080,1'b0,32'd0},         // R6 R7 M ignores TW, retires
        '{1'b0,1'b0,1'b1,1'b1,16'h0880,16'h0880,1'b1,32'h8000_000B}, // R2 highest line
        '{1'b0,1'b1,1'b1,1'b0,16'h0000,16'h0000,1'b1,32'd1},         // R4 M-mode fault
        '{1'b1,1'b0,1'b0,1'b1,16'h0008,16'h0088,1'b1,32'h8000_0003}  // R2 only enabled line counts
    };

    task automatic check(input logic ok, input string req,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check({retire, trap, sleep, wake} == 4'b0, "R1 reset", XLEN'({retire, trap, sleep, wake}), 0);

        // Table walk: each vector presented for one edge, result due 1 ns after it.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            user = VECS[i].user; tw = VECS[i].tw; gie = VECS[i].gie; xok = VECS[i].xok;
            en = VECS[i].en; pend = VECS[i].pend; pc = 32'h0000_1000 + 32'(i * 16); valid = 1'b1;
            @(posedge clk); #1;
            check(trap == VECS[i].trap && retire == !VECS[i].trap, "R11 outcome",
                  XLEN'({retire, trap}), XLEN'({!VECS[i].trap, VECS[i].trap}));
            check(!sleep, "R4 R5 R7 no sleep", XLEN'(sleep), 0);
            check(tpc == (VECS[i].trap ? pc : pc + 4), "R2 R4 R5 R7 target", tpc,
                  VECS[i].trap ? pc : pc + 4);
            if (VECS[i].trap)
                check(cause == VECS[i].cause, "R2 R4 R5 cause", cause, VECS[i].cause);
            @(negedge clk);
            valid = 1'b0;
        end

        // Sleep in M-mode with TW set and nothing enabled, then wake without taking.
        @(negedge clk);
        user = 1'b0; tw = 1'b1; gie = 1'b0; xok = 1'b1; en = '0; pend = '0;
        pc = 32'h0000_2000; valid = 1'b1;
        @(posedge clk); #1;
        check(sleep && !retire && !trap, "R8 R6 enter sleep", XLEN'({sleep, retire, trap}), 3'b100);
        @(negedge clk);
        xok = 1'b0; pc = 32'h0000_3000;   // still valid: must be ignored (R9)
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            check(sleep && !trap && !retire, "R9 stays asleep", XLEN'({sleep, trap, retire}), 3'b100);
        end
        @(negedge clk);
        pend = 16'h0080;                  // pending but not enabled
        repeat (3) begin
            @(posedge clk); #1;
            check(sleep && !wake, "R9 disabled line no wake", XLEN'({sleep, wake}), 2'b10);
        end
        @(negedge clk);
        en = 16'h0080;
        @(posedge clk); #1;
        check(!sleep && wake && retire && !trap, "R10 wake resume",
              XLEN'({sleep, wake, retire, trap}), 4'b0110);
        check(tpc == 32'h0000_2004, "R10 resume pc", tpc, 32'h0000_2004);
        @(negedge clk);
        valid = 1'b0; en = '0; pend = '0; xok = 1'b1;
        @(posedge clk); #1;
        check({wake, retire, trap} == 3'b0, "R11 one-cycle pulse", XLEN'({wake, retire, trap}), 0);

        // Sleep in U-mode, wake by an enabled line with MIE clear: interrupt taken.
        @(negedge clk);
        user = 1'b1; tw = 1'b0; gie = 1'b0; pc = 32'h0000_4000; valid = 1'b1;
        @(posedge clk); #1;
        check(sleep, "R8 user sleep", XLEN'(sleep), 1);
        @(negedge clk);
        valid = 1'b0; en = 16'h0800; pend = 16'h0800;
        @(posedge clk); #1;
        check(!sleep && wake && trap && !retire, "R10 R3 wake trap",
              XLEN'({sleep, wake, trap, retire}), 4'b0110);
        check(cause == 32'h8000_000B, "R10 wake cause", cause, 32'h8000_000B);
        check(tpc == 32'h0000_4004, "R10 wake epc", tpc, 32'h0000_4004);

        @(negedge clk);
        en = '0; pend = '0;
        repeat (2) @(posedge clk);
        summary();
    end
endmodule